// File: doc/BRIEF.md
# Write Blit Engine with Raster Operation

The engine moves a host-supplied bitmap into a frame buffer. After a start command, the host pushes 16-bit words into a data port. The engine splits each word into pixels: one pixel per word at 16 bpp, or up to two byte pixels per word at 8 bpp. Each source pixel is merged with the pixel already in memory through a 4-bit raster-operation code. The engine carries this out as a read followed by a write on a simple synchronous memory port.

Pixel addresses are in pixel units. The destination is walked in one of two ways. In linear mode it is a single run of consecutive addresses. In rectangular mode each line starts at the base address plus the line number times a programmable stride. At 8 bpp a phase bit can move the first pixel of every line to the high byte of that line's first word. The engine then ignores that word's low byte and expects exactly the number of words this layout implies.

The control is one state machine with five states:
- ST_IDLE waits for start. It moves to ST_FETCH, or to ST_FINISH when the width or height is zero.
- ST_FETCH holds ready high and moves to ST_READ when a word is accepted.
- ST_READ issues the destination read and always moves to ST_MODIFY.
- ST_MODIFY writes the merged pixel. It returns to ST_READ when the high byte of the same word is still pending, goes to ST_FINISH after the last pixel of the last line, and otherwise returns to ST_FETCH.
- ST_FINISH raises done for one cycle and returns to ST_IDLE.

Top module: `wblit_engine`

## Requirements
- R1: After reset, busy, done, wr_ready, mem_rd and mem_we are all low.
- R2: Each result bit equals bit {s,d} of the 4-bit code, where s is the source bit (the upper index bit) and d is the destination bit. So 0xC copies the source, 0xA keeps the destination, 0x0 gives zeros and 0xF gives ones.
- R3: At 16 bpp (cfg_depth8=0) each accepted word is one pixel, and exactly width × height words are accepted.
- R4: At 8 bpp with phase 0, a word holds the line's next pixel in bits 7:0 and the following pixel in bits 15:8. When one pixel of the line is left, it is taken from bits 7:0 and bits 15:8 are ignored.
- R5: At 8 bpp with phase 1, the first pixel of every line comes from bits 15:8 of that line's first word, and bits 7:0 of that word are ignored.
- R6: At 8 bpp the engine accepts exactly floor((width+1+phase)/2) words per line, times the height. Every accepted 16-bit word counts as one word.
- R7: In linear mode (cfg_rect=0), pixel k of the blit, counted in raster order, is written at base + k.
- R8: In rectangular mode (cfg_rect=1), pixel c of line r is written at base + r×stride + c.
- R9: Each pixel is a read of its address followed, in the next cycle, by a write to the same address. The written value is the code applied to the source pixel and the read value. At 8 bpp both operands are bits 7:0, and bits 15:8 of the write are zero.
- R10: busy is high from the cycle after start until done. wr_ready is high only while a word is awaited. done is a one-cycle pulse with busy low.
- R11: While not busy, the engine accepts no word and makes no memory access. A start pulse during a blit is ignored.
- R12: A start with zero width or zero height gives done in the next cycle and accepts no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a blit (sampled in idle) |
| cfg_rect | input | 1 | 1 = rectangular destination, 0 = linear |
| cfg_depth8 | input | 1 | 1 = 8 bpp, 0 = 16 bpp |
| cfg_phase | input | 1 | 8 bpp: first pixel of a line in the high byte |
| cfg_rop | input | 4 | Raster-operation code |
| cfg_width | input | DIM_W (8) | Pixels per line |
| cfg_height | input | DIM_W (8) | Number of lines |
| cfg_base | input | ADDR_W (16) | Destination start address (pixels) |
| cfg_stride | input | ADDR_W (16) | Line pitch in rectangular mode (pixels) |
| wr_valid | input | 1 | Host data word present |
| wr_data | input | DATA_W (16) | Host data word |
| wr_ready | output | 1 | Engine takes a word this cycle |
| busy | output | 1 | Blit in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Frame-buffer read request |
| mem_we | output | 1 | Frame-buffer write enable |
| mem_addr | output | ADDR_W (16) | Frame-buffer pixel address |
| mem_wdata | output | DATA_W (16) | Frame-buffer write data |
| mem_rdata | input | DATA_W (16) | Read data, valid one cycle after mem_rd |

## Verification
On every cycle, the assertions check the following:
- every write is preceded by a read of the same address in the previous cycle;
- at 8 bpp, the high byte of every write is zero;
- ready implies busy;
- done lasts one cycle and never coincides with busy;
- an idle engine stays off the memory port;
- the copy and keep codes of the operator behave as stated.

Only the bench's sweeps can show the rest:
- the word count for each depth, phase and width;
- how bytes are picked and discarded;
- the linear and strided address walks;
- the full truth table of all sixteen codes;
- that a start pulse during a blit has no effect.

// File: rtl/wblit_pkg.sv
package wblit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_MODIFY,
        ST_FINISH
    } wb_state_e;

    localparam int ROP_W = 4;

endpackage

// File: rtl/wblit_rop.sv
module wblit_rop #(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        code,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    output logic [DATA_W-1:0] res
);

    // Each result bit picks one bit of the code, indexed by {source, destination}.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign res[i] = code[{src[i], dst[i]}];
    end

    always_comb begin
        if (code == 4'hC) begin
            AST_ROP_COPY: assert (res == src); // R2
        end
        if (code == 4'hA) begin
            AST_ROP_KEEP: assert (res == dst); // R2
        end
    end

endmodule

// File: rtl/wblit_walker.sv
module wblit_walker #(
    parameter int ADDR_W = 16,
    parameter int DIM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              cfg_rect,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_stride,
    output logic [ADDR_W-1:0] addr,
    output logic              line_end,
    output logic              last_line
);

    localparam logic [DIM_W-1:0]  DIM_ONE  = DIM_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] line_base_q;
    logic [ADDR_W-1:0] stride_q;
    logic [DIM_W-1:0]  col_left_q;
    logic [DIM_W-1:0]  rows_left_q;
    logic [DIM_W-1:0]  width_q;
    logic              rect_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            line_base_q <= '0;
            stride_q    <= '0;
            col_left_q  <= '0;
            rows_left_q <= '0;
            width_q     <= '0;
            rect_q      <= 1'b0;
        end else if (load) begin
            addr_q      <= cfg_base;
            line_base_q <= cfg_base;
            stride_q    <= cfg_stride;
            col_left_q  <= cfg_width;
            rows_left_q <= cfg_height;
            width_q     <= cfg_width;
            rect_q      <= cfg_rect;
        end else if (step) begin
            if (col_left_q != DIM_ONE) begin
                addr_q     <= addr_q + ADDR_ONE;
                col_left_q <= col_left_q - DIM_ONE;
            end else begin
                rows_left_q <= rows_left_q - DIM_ONE;
                col_left_q  <= width_q;
                line_base_q <= line_base_q + stride_q;
                if (rect_q) begin
                    addr_q <= line_base_q + stride_q;
                end else begin
                    addr_q <= addr_q + ADDR_ONE;
                end
            end
        end
    end

    assign addr      = addr_q;
    assign line_end  = (col_left_q == DIM_ONE);
    assign last_line = (rows_left_q == DIM_ONE);

endmodule

// File: rtl/wblit_unpack.sv
module wblit_unpack #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              accept,
    input  logic [DATA_W-1:0] wdata,
    input  logic              narrow,
    input  logic              phase,
    input  logic              adv_byte,
    input  logic              new_line,
    output logic [DATA_W-1:0] pixel,
    output logic              hi_sel
);

    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] word_q;
    logic              hi_q;
    logic              line_first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q       <= '0;
            hi_q         <= 1'b0;
            line_first_q <= 1'b0;
        end else if (arm) begin
            hi_q         <= 1'b0;
            line_first_q <= 1'b1;
        end else if (accept) begin
            word_q       <= wdata;
            hi_q         <= narrow & phase & line_first_q;
            line_first_q <= 1'b0;
        end else if (adv_byte) begin
            hi_q <= 1'b1;
        end else if (new_line) begin
            line_first_q <= 1'b1;
        end
    end

    always_comb begin
        if (!narrow) begin
            pixel = word_q;
        end else if (hi_q) begin
            pixel = {{HALF{1'b0}}, word_q[DATA_W-1:HALF]};
        end else begin
            pixel = {{HALF{1'b0}}, word_q[HALF-1:0]};
        end
    end

    assign hi_sel = hi_q;

endmodule

// File: rtl/wblit_engine.sv
module wblit_engine
    import wblit_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DIM_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_rect,
    input  logic              cfg_depth8,
    input  logic              cfg_phase,
    input  logic [ROP_W-1:0]  cfg_rop,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              busy,
    output logic              done,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int HALF = DATA_W / 2;

    wb_state_e state_q, state_d;

    logic [ROP_W-1:0]  rop_q;
    logic              narrow_q;
    logic              phase_q;

    logic              load;
    logic              accept;
    logic              step;
    logic              word_more;
    logic              adv_byte;
    logic              new_line;
    logic              line_end;
    logic              last_line;
    logic              hi_sel;
    logic              empty_cfg;
    logic [DATA_W-1:0] src_pix;
    logic [DATA_W-1:0] dst_pix;
    logic [DATA_W-1:0] rop_res;

    assign empty_cfg = (cfg_width == '0) || (cfg_height == '0);
    assign load      = (state_q == ST_IDLE) && start;
    assign accept    = (state_q == ST_FETCH) && wr_valid;
    assign step      = (state_q == ST_MODIFY);
    assign word_more = narrow_q && !hi_sel && !line_end;
    assign adv_byte  = step && word_more;
    assign new_line  = step && !word_more && line_end;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Mode registers captured at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rop_q    <= '0;
            narrow_q <= 1'b0;
            phase_q  <= 1'b0;
        end else if (load) begin
            rop_q    <= cfg_rop;
            narrow_q <= cfg_depth8;
            phase_q  <= cfg_phase;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = empty_cfg ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (wr_valid) begin
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                state_d = ST_MODIFY;
            end
            ST_MODIFY: begin
                if (word_more) begin
                    state_d = ST_READ;
                end else if (line_end && last_line) begin
                    state_d = ST_FINISH;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        wr_ready = 1'b0;
        mem_rd   = 1'b0;
        mem_we   = 1'b0;
        done     = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_FETCH: begin
                wr_ready = 1'b1;
                busy     = 1'b1;
            end
            ST_READ: begin
                mem_rd = 1'b1;
                busy   = 1'b1;
            end
            ST_MODIFY: begin
                mem_we = 1'b1;
                busy   = 1'b1;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    wblit_walker #(
        .ADDR_W (ADDR_W),
        .DIM_W  (DIM_W)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .cfg_rect   (cfg_rect),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .cfg_base   (cfg_base),
        .cfg_stride (cfg_stride),
        .addr       (mem_addr),
        .line_end   (line_end),
        .last_line  (last_line)
    );

    wblit_unpack #(
        .DATA_W (DATA_W)
    ) u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (load),
        .accept   (accept),
        .wdata    (wr_data),
        .narrow   (narrow_q),
        .phase    (phase_q),
        .adv_byte (adv_byte),
        .new_line (new_line),
        .pixel    (src_pix),
        .hi_sel   (hi_sel)
    );

    assign dst_pix = narrow_q ? {{HALF{1'b0}}, mem_rdata[HALF-1:0]} : mem_rdata;

    wblit_rop #(
        .DATA_W (DATA_W)
    ) u_rop (
        .code (rop_q),
        .src  (src_pix),
        .dst  (dst_pix),
        .res  (rop_res)
    );

    assign mem_wdata = narrow_q ? {{HALF{1'b0}}, rop_res[HALF-1:0]} : rop_res;

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_rd) && mem_addr == $past(mem_addr))); // R9
    AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && narrow_q) |-> (mem_wdata[DATA_W-1:HALF] == '0)); // R9
    AST_READY_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> busy); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_we || wr_ready)); // R11

endmodule

// File: tb/wblit_engine_test.sv
module wblit_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_rect = 1'b0;
    logic        cfg_depth8 = 1'b0;
    logic        cfg_phase = 1'b0;
    logic [3:0]  cfg_rop = 4'h0;
    logic [7:0]  cfg_width = 8'd0;
    logic [7:0]  cfg_height = 8'd0;
    logic [15:0] cfg_base = 16'd0;
    logic [15:0] cfg_stride = 16'd0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic        wr_ready, busy, done, mem_rd, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    wblit_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_rect(cfg_rect),
        .cfg_depth8(cfg_depth8), .cfg_phase(cfg_phase), .cfg_rop(cfg_rop),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_base(cfg_base),
        .cfg_stride(cfg_stride), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .busy(busy), .done(done), .mem_rd(mem_rd),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Frame-buffer model
    logic [15:0] fb [0:511];
    logic [15:0] fb_q = 16'd0;
    logic        init_req = 1'b0;
    int          init_seed = 0;
    int          acc_cnt = 0;
    int          we_cnt = 0;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 1'b0;
    logic [15:0] expm [0:511];
    logic [15:0] words [0:63];

    function automatic logic [15:0] pat(int seed, int a);
        return 16'(a * 40503) ^ 16'(seed * 497) ^ 16'h0F0F;
    endfunction

    function automatic logic [15:0] px(int t, int r, int c);
        return 16'((t * 397) + (r * 113) + (c * 29)) ^ 16'hA55A;
    endfunction

    function automatic logic [15:0] ropf(logic [3:0] code, logic [15:0] s, logic [15:0] d);
        logic [15:0] o;
        for (int i = 0; i < 16; i++) o[i] = code[{s[i], d[i]}];
        return o;
    endfunction

    always @(posedge clk) begin
        if (init_req) begin
            for (int a = 0; a < 512; a++) fb[a] <= pat(init_seed, a);
        end else if (mem_we) begin
            fb[mem_addr[8:0]] <= mem_wdata;
        end
        if (mem_rd) fb_q <= fb[mem_addr[8:0]];
        if (wr_valid && wr_ready) acc_cnt <= acc_cnt + 1;
        if (mem_we) we_cnt <= we_cnt + 1;
    end
    assign mem_rdata = fb_q;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w, input string req);
        int guard = 0;
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        while (!wr_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 100) chk(1'b0, req, "word not taken", 0, 1);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int t = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !wr_ready && !mem_rd && !mem_we, "R1", "outputs after reset",
            {busy, done, wr_ready, mem_rd, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int d8 = 0; d8 < 2; d8++)
        for (int ph = 0; ph < 2; ph++)
        for (int rc = 0; rc < 2; rc++)
        for (int w = 1; w <= 5; w++)
        for (int h = 1; h <= 3; h++) begin
            logic [3:0]  rop;
            logic [7:0]  junk;
            int base, stride, nw, exp_words, acc0, we0, guard, c, a;
            string mreq;
            bit saw_ready;
            t++;
            rop    = 4'(t % 16);
            junk   = 8'(t) ^ 8'hE7;
            base   = 4 + (t % 11);
            stride = w + 1 + (t % 3);

            @(negedge clk);
            init_seed = t;
            init_req  = 1'b1;
            @(negedge clk);
            init_req  = 1'b0;
            for (int i = 0; i < 512; i++) expm[i] = pat(t, i);

            // build host words line by line
            nw = 0;
            for (int r = 0; r < h; r++) begin
                if (d8 == 1) begin
                    c = 0;
                    if (ph == 1) begin
                        words[nw] = {px(t, r, 0)[7:0], junk};
                        nw++;
                        c = 1;
                    end
                    while (c < w) begin
                        if (c + 1 < w) begin
                            words[nw] = {px(t, r, c + 1)[7:0], px(t, r, c)[7:0]};
                            c += 2;
                        end else begin
                            words[nw] = {junk, px(t, r, c)[7:0]};
                            c += 1;
                        end
                        nw++;
                    end
                end else begin
                    for (int cc = 0; cc < w; cc++) begin
                        words[nw] = px(t, r, cc);
                        nw++;
                    end
                end
            end

            // expected image
            for (int r = 0; r < h; r++)
                for (int cc = 0; cc < w; cc++) begin
                    logic [15:0] s, dv, res;
                    a = (rc == 1) ? base + r * stride + cc : base + r * w + cc;
                    if (d8 == 1) begin
                        s   = {8'h00, px(t, r, cc)[7:0]};
                        dv  = {8'h00, expm[a][7:0]};
                        res = ropf(rop, s, dv);
                        expm[a] = {8'h00, res[7:0]};
                    end else begin
                        expm[a] = ropf(rop, px(t, r, cc), expm[a]);
                    end
                end

            exp_words = (d8 == 1) ? ((w + 1 + ph) / 2) * h : w * h;

            @(negedge clk);
            cfg_rect   = rc[0];
            cfg_depth8 = d8[0];
            cfg_phase  = ph[0];
            cfg_rop    = rop;
            cfg_width  = 8'(w);
            cfg_height = 8'(h);
            cfg_base   = 16'(base);
            cfg_stride = 16'(stride);
            acc0 = acc_cnt;
            pulse_start();
            // R10: busy and ready right after start
            chk(busy && wr_ready, "R10", "busy/ready after start", {busy, wr_ready}, 3);

            for (int k = 0; k < nw; k++) begin
                if (k == 1 && (t % 4) == 0) begin
                    // R11: start during a blit with different settings is ignored
                    @(negedge clk);
                    start = 1'b1; cfg_width = 8'd7; cfg_rop = ~rop; cfg_base = 16'd200;
                    @(negedge clk);
                    start = 1'b0; cfg_width = 8'(w); cfg_rop = rop; cfg_base = 16'(base);
                end
                push(words[k], (d8 == 1) ? "R6" : "R3");
            end

            guard = 0;
            while (!done && guard < 200) begin
                @(negedge clk);
                guard++;
            end
            chk(done && !busy, "R10", "done pulse with busy low", {done, busy}, 2);
            chk(acc_cnt - acc0 == exp_words, (d8 == 1) ? "R6" : "R3", "words accepted",
                acc_cnt - acc0, exp_words);
            @(negedge clk);
            chk(!done, "R10", "done lasts one cycle", done, 0);

            // R11: words after completion are refused and cause no access
            we0 = we_cnt; acc0 = acc_cnt; saw_ready = 1'b0;
            wr_valid = 1'b1; wr_data = 16'hFFFF;
            repeat (4) begin
                @(negedge clk);
                if (wr_ready) saw_ready = 1'b1;
            end
            wr_valid = 1'b0;
            chk(!saw_ready && we_cnt == we0 && acc_cnt == acc0, "R11", "extra word after done",
                we_cnt - we0 + acc_cnt - acc0, 0);

            mreq = (d8 == 0) ? "R3" : ((ph == 1) ? "R5" : "R4");
            for (int i = 0; i < 64; i++)
                chk(fb[i] == expm[i], mreq,
                    $sformatf("R2 R9 %s image addr %0d", (rc == 1) ? "R8" : "R7", i),
                    fb[i], expm[i]);
        end

        // R12: zero width, then zero height
        for (int z = 0; z < 2; z++) begin
            int acc0, we0;
            @(negedge clk);
            cfg_width  = (z == 0) ? 8'd0 : 8'd4;
            cfg_height = (z == 0) ? 8'd3 : 8'd0;
            acc0 = acc_cnt; we0 = we_cnt;
            wr_valid = 1'b1;
            pulse_start();
            chk(done && !busy && !wr_ready, "R12", "empty blit finishes at once",
                {done, busy, wr_ready}, 4);
            @(negedge clk);
            wr_valid = 1'b0;
            chk(acc_cnt == acc0 && we_cnt == we0, "R12", "empty blit moves nothing",
                acc_cnt - acc0 + we_cnt - we0, 0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule